// File: doc/BRIEF.md
# Minimum-Angle Redundant State Selector

This block chooses the gate vector for one leg of a four-level converter built around three flying capacitors. Each time the controller pulses a strobe, the block takes four inputs: the output level wanted for the next switching period, the sign of the load current, and two signed fixed-point voltage errors, one for the middle capacitor and one for the inner capacitor. It then returns a 3-bit switch vector that produces that level. Levels 1 and 2 can each be reached by three redundant switch states. For these levels the block picks the state whose precomputed unit direction in the error plane lies closest in angle to the error, after the error has been corrected for the current sign. Applying that state drives the capacitor voltages back toward their targets.

Arc-cosine is monotonic, and scaling the error by its positive norm does not change which candidate ranks first. The block therefore skips both operations. It scores each candidate by the dot product of its Q1.14 unit direction with the raw, sign-corrected error, and keeps the largest score. The chosen vector is registered together with its three signed configuration components, and the registers hold until the next strobe.

Top module: `mad_state_sel`

## Requirements
- R1: While `rst` is high, at each clock edge `gate` is cleared to 000 and all three configuration outputs are cleared to 0.
- R2: After a strobe, the number of ones in `gate` equals the requested `level`. `level` is an unsigned code 0..3. In `gate`, bit 2 is the outer switch T1, bit 1 is T2 and bit 0 is T3.
- R3: Level 0 always gives 000 and level 3 always gives 111, whatever the errors and the current sign.
- R4: The configuration outputs are 2-bit two's complement values in {-1,0,+1}. `cfg_s1` = T1. `cfg_s2` is +1 when T1=0 and T2=1, -1 when T1=1 and T2=0, and 0 otherwise. `cfg_s3` follows the same rule applied to T2 and T3.
- R5: For levels 1 and 2, the block picks the candidate with the largest score ux*e2 + uy*e3. The unit directions (ux,uy) are in Q1.14. Gate 001: (0,16384). Gate 010: (14654,-7327). Gate 100: (-16384,0). Gate 011: (16384,0). Gate 101: (-14654,7327). Gate 110: (0,-16384).
- R6: When `cur_neg` is 1, both errors are negated before scoring.
- R7: A tie in score goes to the candidate with the lowest gate value. With both errors zero, level 1 therefore gives 001 and level 2 gives 011.
- R8: The outputs update at the clock edge that samples `strobe` high. Without a strobe they hold their values, whatever the other inputs do.
- R9: Errors across the full signed range give the correct choice, including the most negative code under negation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Start a selection with the current inputs |
| level | input | 2 | Requested output level, 0..3 |
| cur_neg | input | 1 | 1 when load current is negative |
| err_c2 | input | EW | Signed error of middle capacitor voltage |
| err_c3 | input | EW | Signed error of inner capacitor voltage |
| gate | output | 3 | Selected switch vector {T1,T2,T3} |
| cfg_s1 | output | 2 | Configuration component 1, signed |
| cfg_s2 | output | 2 | Configuration component 2, signed |
| cfg_s3 | output | 2 | Configuration component 3, signed |

## Verification
The assertions assume three things about the inputs: `level`, `cur_neg` and both errors are stable across the sampling edge, a strobe lasts one cycle, and reset is held for at least one edge. The zero-error property also assumes that both errors are exactly zero in the strobe cycle. The stimulus drives every input on the falling edge and lowers the strobe right after the edge that sampled it. It then changes the errors and the level between strobes, which exercises the hold behaviour without touching the edge.

// File: rtl/mad_pkg.sv
package mad_pkg;

    localparam int UW    = 16;   // unit-direction width, Q1.14
    localparam int NCAND = 3;    // redundant states per inner level

    localparam logic signed [UW-1:0] U_ONE = 16'sd16384;
    localparam logic signed [UW-1:0] U_MAJ = 16'sd14654;
    localparam logic signed [UW-1:0] U_MIN = 16'sd7327;

    typedef enum logic [1:0] {LVL0, LVL1, LVL2, LVL3} level_e;

    typedef logic signed [1:0] comp_t;

    typedef struct packed {
        comp_t s1;
        comp_t s2;
        comp_t s3;
    } cfg_t;

    typedef struct packed {
        logic signed [UW-1:0] ux;
        logic signed [UW-1:0] uy;
    } dir_t;

    // signed step between neighbouring switch signals
    function automatic comp_t step_of(logic prev_t, logic cur_t);
        if (cur_t && !prev_t)      return 2'sb01;
        else if (prev_t && !cur_t) return 2'sb11;
        else                       return 2'sb00;
    endfunction

    function automatic cfg_t cfg_of(logic [2:0] g);
        cfg_t c;
        c.s1 = {1'b0, g[2]};
        c.s2 = step_of(g[2], g[1]);
        c.s3 = step_of(g[1], g[0]);
        return c;
    endfunction

    // unit direction of (2*s2, s3), since C2 is half of C3
    function automatic dir_t dir_of(logic [2:0] g);
        dir_t d;
        case (g)
            3'b001:  begin d.ux = '0;     d.uy = U_ONE;  end
            3'b010:  begin d.ux = U_MAJ;  d.uy = -U_MIN; end
            3'b100:  begin d.ux = -U_ONE; d.uy = '0;     end
            3'b011:  begin d.ux = U_ONE;  d.uy = '0;     end
            3'b101:  begin d.ux = -U_MAJ; d.uy = U_MIN;  end
            3'b110:  begin d.ux = '0;     d.uy = -U_ONE; end
            default: begin d.ux = '0;     d.uy = '0;     end
        endcase
        return d;
    endfunction

    // k-th candidate of an inner level, in ascending gate order
    function automatic logic [2:0] cand_gate(level_e lv, int k);
        logic [2:0] one_hot;
        one_hot = 3'b001 << k;
        if (lv == LVL1) return one_hot;
        else            return ~(3'b100 >> k);
    endfunction

endpackage

// File: rtl/mad_err_cond.sv
module mad_err_cond #(
    parameter int EW = 16
) (
    input  logic                 cur_neg,
    input  logic signed [EW-1:0] err_a,
    input  logic signed [EW-1:0] err_b,
    output logic signed [EW:0]   cor_a,
    output logic signed [EW:0]   cor_b
);
    logic signed [EW:0] ext_a;
    logic signed [EW:0] ext_b;

    always_comb begin
        ext_a = (EW+1)'(err_a);
        ext_b = (EW+1)'(err_b);
        cor_a = cur_neg ? -ext_a : ext_a;
        cor_b = cur_neg ? -ext_b : ext_b;
    end
endmodule

// File: rtl/mad_score.sv
module mad_score
    import mad_pkg::*;
#(
    parameter int EW = 16,
    localparam int SW = EW + 1 + UW + 1
) (
    input  dir_t                 dir,
    input  logic signed [EW:0]   cor_a,
    input  logic signed [EW:0]   cor_b,
    output logic signed [SW-1:0] score
);
    logic signed [SW-1:0] prod_a;
    logic signed [SW-1:0] prod_b;

    always_comb begin
        prod_a = SW'(cor_a) * SW'(dir.ux);
        prod_b = SW'(cor_b) * SW'(dir.uy);
        score  = prod_a + prod_b;
    end
endmodule

// File: rtl/mad_argmax.sv
module mad_argmax
    import mad_pkg::*;
#(
    parameter int SW = 34,
    localparam int IW = $clog2(NCAND)
) (
    input  logic signed [SW-1:0] score [NCAND],
    output logic [IW-1:0]        sel
);
    logic signed [SW-1:0] best;

    always_comb begin
        sel  = '0;
        best = score[0];
        for (int k = 1; k < NCAND; k++) begin
            if (score[k] > best) begin   // strict: ties keep lower index
                best = score[k];
                sel  = IW'(k);
            end
        end
    end
endmodule

// File: rtl/mad_state_sel.sv
module mad_state_sel
    import mad_pkg::*;
#(
    parameter int EW = 16,
    localparam int SW = EW + 1 + UW + 1,
    localparam int IW = $clog2(NCAND)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strobe,
    input  logic [1:0]           level,
    input  logic                 cur_neg,
    input  logic signed [EW-1:0] err_c2,
    input  logic signed [EW-1:0] err_c3,
    output logic [2:0]           gate,
    output logic [1:0]           cfg_s1,
    output logic [1:0]           cfg_s2,
    output logic [1:0]           cfg_s3
);
    level_e               lvl;
    logic signed [EW:0]   cor_a;
    logic signed [EW:0]   cor_b;
    logic [2:0]           cand [NCAND];
    logic signed [SW-1:0] score [NCAND];
    logic [IW-1:0]        sel;
    logic [2:0]           next_gate;
    cfg_t                 cfg_q;

    assign lvl = level_e'(level);

    mad_err_cond #(.EW(EW)) u_cond (
        .cur_neg (cur_neg),
        .err_a   (err_c2),
        .err_b   (err_c3),
        .cor_a   (cor_a),
        .cor_b   (cor_b)
    );

    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        assign cand[k] = cand_gate(lvl, k);
        mad_score #(.EW(EW)) u_score (
            .dir   (dir_of(cand[k])),
            .cor_a (cor_a),
            .cor_b (cor_b),
            .score (score[k])
        );
    end

    mad_argmax #(.SW(SW)) u_pick (
        .score (score),
        .sel   (sel)
    );

    always_comb begin
        case (lvl)
            LVL0:    next_gate = 3'b000;
            LVL3:    next_gate = 3'b111;
            default: next_gate = cand[sel];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate  <= 3'b000;
            cfg_q <= '0;
        end else if (strobe) begin
            gate  <= next_gate;
            cfg_q <= cfg_of(next_gate);
        end
    end

    assign cfg_s1 = cfg_q.s1;
    assign cfg_s2 = cfg_q.s2;
    assign cfg_s3 = cfg_q.s3;

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (gate == 3'b000 && cfg_s1 == 2'b00 && cfg_s2 == 2'b00 && cfg_s3 == 2'b00)); // R1
    AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (rst) strobe |=> ($countones(gate) == int'($past(level)))); // R2
    AST_OUTER_LOW: assert property (@(posedge clk) disable iff (rst) (strobe && level == 2'd0) |=> (gate == 3'b000)); // R3
    AST_OUTER_HIGH: assert property (@(posedge clk) disable iff (rst) (strobe && level == 2'd3) |=> (gate == 3'b111)); // R3
    AST_CFG_TELESCOPE: assert property (@(posedge clk) disable iff (rst) (($signed(cfg_s1) + $signed(cfg_s2) + $signed(cfg_s3)) == $signed({1'b0, gate[0]}))); // R4
    AST_ZERO_ERR_L1: assert property (@(posedge clk) disable iff (rst) (strobe && level == 2'd1 && err_c2 == 0 && err_c3 == 0) |=> (gate == 3'b001)); // R7
    AST_ZERO_ERR_L2: assert property (@(posedge clk) disable iff (rst) (strobe && level == 2'd2 && err_c2 == 0 && err_c3 == 0) |=> (gate == 3'b011)); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !strobe |=> ($stable(gate) && $stable(cfg_s2) && $stable(cfg_s3))); // R8

endmodule

// File: tb/mad_state_sel_bench.sv
module mad_state_sel_bench;
    localparam int EW = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 strobe = 1'b0;
    logic [1:0]           level = 2'd0;
    logic                 cur_neg = 1'b0;
    logic signed [EW-1:0] err_c2 = '0;
    logic signed [EW-1:0] err_c3 = '0;
    logic [2:0]           gate;
    logic [1:0]           cfg_s1, cfg_s2, cfg_s3;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    mad_state_sel #(.EW(EW)) u_mad_state_sel (
        .clk(clk), .rst(rst), .strobe(strobe), .level(level),
        .cur_neg(cur_neg), .err_c2(err_c2), .err_c3(err_c3),
        .gate(gate), .cfg_s1(cfg_s1), .cfg_s2(cfg_s2), .cfg_s3(cfg_s3)
    );

    function automatic longint ux_of(int g);
        case (g)
            1: return 0;      2: return 14654;  4: return -16384;
            3: return 16384;  5: return -14654; 6: return 0;
            default: return 0;
        endcase
    endfunction

    function automatic longint uy_of(int g);
        case (g)
            1: return 16384;  2: return -7327;  4: return 0;
            3: return 0;      5: return 7327;   6: return -16384;
            default: return 0;
        endcase
    endfunction

    function automatic int model_gate(int lv, bit neg, longint e2, longint e3);
        int c [3];
        int best_g;
        longint best_s, s;
        if (lv == 0) return 0;
        if (lv == 3) return 7;
        if (neg) begin e2 = -e2; e3 = -e3; end
        if (lv == 1) begin c[0] = 1; c[1] = 2; c[2] = 4; end
        else         begin c[0] = 3; c[1] = 5; c[2] = 6; end
        best_g = c[0];
        best_s = ux_of(c[0]) * e2 + uy_of(c[0]) * e3;
        for (int k = 1; k < 3; k++) begin
            s = ux_of(c[k]) * e2 + uy_of(c[k]) * e3;
            if (s > best_s) begin best_s = s; best_g = c[k]; end
        end
        return best_g;
    endfunction

    function automatic logic [1:0] model_step(bit p, bit q);
        if (q && !p) return 2'b01;
        if (p && !q) return 2'b11;
        return 2'b00;
    endfunction

    task automatic check_out(string req, int exp_g);
        logic [2:0] g;
        logic [1:0] e1, e2x, e3x;
        g   = 3'(exp_g);
        e1  = {1'b0, g[2]};
        e2x = model_step(g[2], g[1]);
        e3x = model_step(g[1], g[0]);
        n_vec++;
        if (gate !== g) begin
            n_fail++;
            $display("FAIL %s gate: actual %b expected %b", req, gate, g);
        end else if (cfg_s1 !== e1 || cfg_s2 !== e2x || cfg_s3 !== e3x) begin
            n_fail++;
            $display("FAIL R4 cfg: actual %b %b %b expected %b %b %b",
                     cfg_s1, cfg_s2, cfg_s3, e1, e2x, e3x);
        end
    endtask

    task automatic apply(string req, int lv, bit neg, int e2, int e3);
        @(negedge clk);
        level = 2'(lv); cur_neg = neg;
        err_c2 = EW'(e2); err_c3 = EW'(e3);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        check_out(req, model_gate(lv, neg, longint'(e2), longint'(e3)));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        int held;
        seed_dummy = $urandom(20250227);
        repeat (3) @(negedge clk);
        check_out("R1", 0);             // reset state
        rst = 1'b0;

        apply("R3", 0, 1'b0, 1200, -800);     // level 0
        apply("R3", 3, 1'b1, -5000, 300);     // level 3
        apply("R7", 1, 1'b0, 0, 0);           // tie -> 001
        apply("R7", 2, 1'b1, 0, 0);           // tie -> 011
        apply("R5", 1, 1'b0, 0, 1000);        // -> 001
        apply("R6", 1, 1'b1, 0, 1000);        // negated -> 010
        apply("R5", 1, 1'b0, -1000, 0);       // -> 100
        apply("R5", 2, 1'b0, 2000, 100);      // -> 011
        apply("R6", 2, 1'b1, 2000, 100);      // -> 101
        apply("R9", 2, 1'b1, -32768, -32768); // most negative
        apply("R9", 1, 1'b0, 32767, -32768);

        // R8: hold with no strobe while inputs move
        held = int'(gate);
        @(negedge clk);
        level = 2'd3; err_c2 = 16'sd9999; err_c3 = -16'sd9999; cur_neg = 1'b1;
        repeat (3) @(negedge clk);
        check_out("R8", held);

        // R2/R5/R6 random sweep
        for (int i = 0; i < 400; i++) begin
            int lv, e2, e3;
            bit neg;
            lv  = int'($urandom_range(0, 3));
            neg = 1'($urandom_range(0, 1));
            e2  = int'($signed(16'($urandom)));
            e3  = int'($signed(16'($urandom)));
            if (i % 5 == 0) begin
                e2 = e2 / 256; e3 = e3 / 256;
            end
            apply("R2/R5", lv, neg, e2, e3);
        end

        // R1: reset after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check_out("R1", 0);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule